// File: doc/BRIEF.md
# Flash Chip-Erase Command Sequencer

This block is the command front end and status source for a 16-bit NOR-style flash array, built as synthesizable logic around a small on-chip word array. A host issues single-cycle write and read strobes with an address and data word. In read-array mode a read returns the addressed word. A chip erase needs six writes in a fixed order: two unlock writes, an erase-setup write, two more unlock writes and a confirm write. Any write that breaks this order abandons the sequence, and the interface stays in read-array mode.

Once the confirm write is accepted, an internal controller runs two passes over the array. The first pass clears every word to 0000h. The second pass sets every word to FFFFh. Throughout the operation, reads return a status word instead of array data. A polling bit shows whether the operation has finished. Two toggle bits flip on each read while the controller is busy. A failure bit reports an erase failure, which the bench forces through an injection input. A supply-lockout input blocks every write while it is high.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset the interface is in read-array mode and word i of the array holds 5A00h + i.
- R2: In read-array mode, a read strobe returns on `rdata`, one clock later, the word indexed by the low log2(WORDS) address bits.
- R3: An erase starts after six accepted writes with these address/data pairs: 555h/00AAh, 2AAh/0055h, 555h/0080h, 555h/00AAh, 2AAh/0055h, 555h/0010h. Both address and all 16 data bits are compared. Reads between these writes do not disturb the sequence.
- R4: A write whose address or data does not match the expected cycle resets the sequence to its first cycle and leaves the interface in read-array mode.
- R5: A write made while `supply_low` is high is ignored. It neither advances nor aborts the sequence.
- R6: While the operation runs, each read returns status with bit 7 = 0 and bit 5 = 0. Bits 15..8, 4, 3, 1 and 0 are 0 in every status word.
- R7: Bits 6 and 2 carry the same value. They read 0 on the first status read of an operation and invert on each further read while the operation is busy.
- R8: The first read after the operation ends returns bit 7 = 1. Its bits 6 and 2 equal the inverse of the last busy read's bit 6.
- R9: Bit 5 of the completion status is 1 exactly when `fail_inject` was high at the end of at least one word's erase step.
- R10: The controller first writes 0000h to every word, then writes FFFFh to every word. A word whose erase step sees `fail_inject` high keeps 0000h.
- R11: Writes during the operation are ignored. After completion, either the first status read or a write of 00F0h returns the interface to read-array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| supply_low | input | 1 | Supply below lockout threshold, blocks writes |
| fail_inject | input | 1 | Forces the current erase step to fail |
| rdata | output | 16 | Read data or status, registered |

## Verification
The bench builds the block with ADDR_W = 11, WORDS = 16 and STEP_CYCLES = 3. The sixteen-word array is small enough for every word to be read back after each operation. Each operation then lasts 96 cycles, long enough for dozens of busy status reads in which the toggle bits can be followed read by read. It also leaves room to insert stray and locked-out writes in the middle of an erase. Randomly placed mismatches at each of the six sequence positions exercise every abort path before any erase runs.

// File: rtl/fes_pkg.sv
package fes_pkg;

   typedef enum logic {MODE_READ, MODE_STATUS} mode_t;
   typedef enum logic [1:0] {PH_IDLE, PH_PROG, PH_ERASE} phase_t;

   localparam int SEQ_LEN = 6;

   function automatic logic [10:0] seq_addr(input logic [2:0] pos);
      case (pos)
         3'd1, 3'd4: seq_addr = 11'h2AA;
         default:    seq_addr = 11'h555;
      endcase
   endfunction

   function automatic logic [15:0] seq_data(input logic [2:0] pos);
      case (pos)
         3'd0, 3'd3: seq_data = 16'h00AA;
         3'd1, 3'd4: seq_data = 16'h0055;
         3'd2:       seq_data = 16'h0080;
         default:    seq_data = 16'h0010;
      endcase
   endfunction

endpackage

// File: rtl/fes_cmd_decode.sv
module fes_cmd_decode
   import fes_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       wdata,
   input  logic              supply_low,
   input  logic              busy,
   output logic              start,
   output logic              status_mode
);

   logic [2:0] seq_q;
   mode_t      mode_q;
   logic       wr_ok;
   logic       hit;

   always_comb begin
      wr_ok       = wr_en && !supply_low;
      hit         = (addr == ADDR_W'(seq_addr(seq_q))) && (wdata == seq_data(seq_q));
      start       = wr_ok && (mode_q == MODE_READ) && hit && (seq_q == 3'(SEQ_LEN-1));
      status_mode = (mode_q == MODE_STATUS);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q  <= '0;
         mode_q <= MODE_READ;
      end else if (mode_q == MODE_READ) begin
         if (wr_ok) begin
            if (!hit) begin
               seq_q <= '0;
            end else if (seq_q == 3'(SEQ_LEN-1)) begin
               seq_q  <= '0;
               mode_q <= MODE_STATUS;
            end else begin
               seq_q <= seq_q + 3'd1;
            end
         end
      end else if (!busy) begin
         if (rd_en || (wr_ok && wdata == 16'h00F0)) mode_q <= MODE_READ;
      end
   end

   AST_LOCKOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && supply_low && !rd_en |=> $stable(seq_q) && $stable(mode_q)); // R5
   AST_START_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy && !status_mode); // R3
   AST_SEQ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      seq_q < 3'(SEQ_LEN)); // R4

endmodule

// File: rtl/fes_pe_engine.sv
module fes_pe_engine
   import fes_pkg::*;
#(
   parameter int WORDS       = 16,
   parameter int STEP_CYCLES = 3,
   localparam int IDX_W      = $clog2(WORDS),
   localparam int STEP_W     = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             fail_inject,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [15:0]      rd_word,
   output logic             busy,
   output logic             fail
);

   phase_t           phase_q;
   logic [IDX_W-1:0] idx_q;
   logic             fail_q;
   logic             step_last;
   logic [15:0]      mem [WORDS];

   generate
      if (STEP_CYCLES == 1) begin : g_single
         assign step_last = 1'b1;
      end else begin : g_multi
         logic [STEP_W-1:0] step_q;
         assign step_last = (step_q == STEP_W'(STEP_CYCLES-1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                    step_q <= '0;
            else if (start || step_last || phase_q == PH_IDLE) step_q <= '0;
            else                                           step_q <= step_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         idx_q   <= '0;
         fail_q  <= 1'b0;
         for (int i = 0; i < WORDS; i++) mem[i] <= 16'h5A00 + 16'(i);
      end else if (start) begin
         phase_q <= PH_PROG;
         idx_q   <= '0;
         fail_q  <= 1'b0;
      end else if (phase_q != PH_IDLE && step_last) begin
         if (phase_q == PH_PROG)  mem[idx_q] <= 16'h0000;
         else if (!fail_inject)   mem[idx_q] <= 16'hFFFF;
         if (phase_q == PH_ERASE && fail_inject) fail_q <= 1'b1;
         if (idx_q == IDX_W'(WORDS-1)) begin
            idx_q   <= '0;
            phase_q <= (phase_q == PH_PROG) ? PH_ERASE : PH_IDLE;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign rd_word = mem[rd_idx];
   assign busy    = (phase_q != PH_IDLE);
   assign fail    = fail_q;

   AST_PROG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q == PH_PROG && step_last && !start |=> mem[$past(idx_q)] == 16'h0000); // R10
   AST_ERASE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q == PH_ERASE && step_last && !fail_inject && !start |=> mem[$past(idx_q)] == 16'hFFFF); // R10
   AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fail_q && !start |=> fail_q); // R9

endmodule

// File: rtl/fes_status_out.sv
module fes_status_out (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rd_en,
   input  logic        start,
   input  logic        status_mode,
   input  logic        busy,
   input  logic        fail,
   input  logic [15:0] rd_word,
   output logic [15:0] rdata
);

   logic        tog_q;
   logic [15:0] stat_word;

   always_comb begin
      stat_word      = '0;
      stat_word[7]   = !busy;
      stat_word[6]   = tog_q;
      stat_word[5]   = fail && !busy;
      stat_word[2]   = tog_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_q <= 1'b0;
         rdata <= '0;
      end else begin
         if (start)                             tog_q <= 1'b0;
         else if (rd_en && status_mode && busy) tog_q <= !tog_q;
         if (rd_en) rdata <= status_mode ? stat_word : rd_word;
      end
   end

   AST_BUSY_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && status_mode && busy |=> rdata[7] == 1'b0 && rdata[5] == 1'b0); // R6
   AST_TOGGLE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && status_mode |=> rdata[6] == rdata[2]); // R7
   AST_DONE_POLL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && status_mode && !busy |=> rdata[7] == 1'b1); // R8

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
   import fes_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int WORDS       = 16,
   parameter int STEP_CYCLES = 3,
   localparam int IDX_W      = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       wdata,
   input  logic              supply_low,
   input  logic              fail_inject,
   output logic [15:0]       rdata
);

   generate
      if (ADDR_W < 11)      begin : g_bad_addr  $error("ADDR_W must cover 555h"); end
      if (WORDS < 2)        begin : g_bad_words $error("WORDS must be at least 2"); end
      if (IDX_W > ADDR_W)   begin : g_bad_idx   $error("array larger than address space"); end
      if (STEP_CYCLES < 1)  begin : g_bad_step  $error("STEP_CYCLES must be positive"); end
   endgenerate

   logic        start;
   logic        status_mode;
   logic        busy;
   logic        fail;
   logic [15:0] rd_word;

   fes_cmd_decode #(.ADDR_W(ADDR_W)) u_decode (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .supply_low(supply_low), .busy(busy),
      .start(start), .status_mode(status_mode)
   );

   fes_pe_engine #(.WORDS(WORDS), .STEP_CYCLES(STEP_CYCLES)) u_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .fail_inject(fail_inject),
      .rd_idx(addr[IDX_W-1:0]), .rd_word(rd_word), .busy(busy), .fail(fail)
   );

   fes_status_out u_status (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .start(start),
      .status_mode(status_mode), .busy(busy), .fail(fail),
      .rd_word(rd_word), .rdata(rdata)
   );

   AST_BUSY_IN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> status_mode); // R11

endmodule

// File: tb/flash_erase_seq_bench.sv
module flash_erase_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 11;
   localparam int WORDS      = 16;
   localparam int STEP_CYC   = 3;
   localparam int OP_CYCLES  = 2 * WORDS * STEP_CYC;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic              rd_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [15:0]       wdata = '0;
   logic              supply_low = 1'b0;
   logic              fail_inject = 1'b0;
   logic [15:0]       rdata;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [15:0] model [WORDS];

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_erase_seq #(.ADDR_W(ADDR_W), .WORDS(WORDS), .STEP_CYCLES(STEP_CYC)) u_flash_erase_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .supply_low(supply_low), .fail_inject(fail_inject), .rdata(rdata)
   );

   function automatic logic [ADDR_W-1:0] exp_addr(input int pos);
      return (pos == 1 || pos == 4) ? ADDR_W'(11'h2AA) : ADDR_W'(11'h555);
   endfunction

   function automatic logic [15:0] exp_data(input int pos);
      case (pos)
         0, 3:    return 16'h00AA;
         1, 4:    return 16'h0055;
         2:       return 16'h0080;
         default: return 16'h0010;
      endcase
   endfunction

   function automatic logic [15:0] busy_word(input logic tog);
      return {8'h00, 1'b0, tog, 1'b0, 2'b00, tog, 2'b00};
   endfunction

   function automatic logic [15:0] done_word(input logic tog, input logic failed);
      return {8'h00, 1'b1, tog, failed, 2'b00, tog, 2'b00};
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [ADDR_W-1:0] a, input logic [15:0] d, input logic low);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d; supply_low = low;
      @(negedge clk);
      wr_en = 1'b0; supply_low = 1'b0;
   endtask

   task automatic do_read(input logic [ADDR_W-1:0] a, output logic [15:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic full_seq(input bit low);
      for (int j = 0; j < 6; j++) do_write(exp_addr(j), exp_data(j), low);
   endtask

   // polls until completion; checks toggle/poll bits, leaves interface in read mode
   task automatic poll_done(input logic exp_fail);
      logic [15:0] d;
      logic tog = 1'b0;
      bit done = 1'b0;
      for (int n = 0; n < 400 && !done; n++) begin
         do_read(ADDR_W'(n), d);
         if (d[7] == 1'b0) begin
            chk("R6 R7 busy status", d, busy_word(tog));
            tog = !tog;
         end else begin
            chk("R8 R9 completion status", d, done_word(tog, exp_fail));
            done = 1'b1;
         end
      end
      if (!done) chk("R8 completion never seen", 16'h0000, 16'h0080);
   endtask

   task automatic check_array(input string req);
      logic [15:0] d;
      for (int i = 0; i < WORDS; i++) begin
         do_read(ADDR_W'(i), d);
         chk(req, d, model[i]);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      void'($urandom(32'd20240611));
      for (int i = 0; i < WORDS; i++) model[i] = 16'h5A00 + 16'(i);

      repeat (3) @(negedge clk);
      chk("R1 rdata reset", rdata, 16'h0000);
      rst_n = 1'b1;

      // R1 R2: reset contents, including address upper bits ignored for index
      check_array("R1 R2 reset contents");
      do_read(ADDR_W'(11'h7F5), d);
      chk("R2 low index bits", d, model[5]);

      // R4 R3: random aborts at every position, random reads in between
      for (int t = 0; t < 24; t++) begin
         int k = t % 6;
         for (int j = 0; j < k; j++) begin
            do_write(exp_addr(j), exp_data(j), 1'b0);
            if ($urandom % 2 == 1) begin
               int r = int'($urandom % WORDS);
               do_read(ADDR_W'(r), d);
               chk("R3 read during sequence", d, model[r]);
            end
         end
         if ($urandom % 2 == 0)
            do_write(exp_addr(k), exp_data(k) ^ 16'(1 + $urandom % 255), 1'b0);
         else
            do_write(exp_addr(k) ^ ADDR_W'(1 + $urandom % 7), exp_data(k), 1'b0);
         begin
            int r = int'($urandom % WORDS);
            do_read(ADDR_W'(r), d);
            chk("R4 abort returns array data", d, model[r]);
         end
      end

      // R5: complete sequence under lockout does nothing
      full_seq(1'b1);
      do_read(ADDR_W'(3), d);
      chk("R5 locked sequence ignored", d, model[3]);

      // R3 R5: valid sequence with locked-out garbage writes interleaved
      for (int j = 0; j < 6; j++) begin
         do_write(exp_addr(j), exp_data(j), 1'b0);
         do_write(ADDR_W'(11'h555), 16'h00F0, 1'b1);
      end
      // R11: writes while busy ignored (no exit, no abort)
      do_write(ADDR_W'(11'h555), 16'h00F0, 1'b0);
      do_write(ADDR_W'(11'h555), 16'h00AA, 1'b0);
      poll_done(1'b0);
      for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
      check_array("R10 R11 erased to FFFF");

      // R9 R10: failure injected throughout, words keep the pre-programmed zeros
      fail_inject = 1'b1;
      full_seq(1'b0);
      poll_done(1'b1);
      fail_inject = 1'b0;
      for (int i = 0; i < WORDS; i++) model[i] = 16'h0000;
      check_array("R10 pre-program to 0000");

      // R11: exit via F0 write without any status read
      full_seq(1'b0);
      repeat (OP_CYCLES + 10) @(negedge clk);
      do_write(ADDR_W'(11'h123), 16'h00F0, 1'b0);
      for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
      do_read(ADDR_W'(7), d);
      chk("R11 F0 exit to read mode", d, model[7]);
      do_read(ADDR_W'(2), d);
      chk("R11 still read mode", d, model[2]);

      // R7 R8: busy read count check with spaced polls
      full_seq(1'b0);
      repeat (20) @(negedge clk);
      poll_done(1'b0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule